// File: doc/BRIEF.md
# Bit-Slice Logic and Arithmetic Unit

This block is a small combinational arithmetic and logic unit. It is built from identical one-bit cells joined by a single ripple path that runs from the least significant cell to the most significant one. A two-bit mode input decides what that path carries and what each cell puts on its result bit.

In logic mode, each cell applies a four-bit function code to its own operand bits. Each code bit enables one of the four operand combinations, so the sixteen codes cover every two-input bitwise function. In add mode, the path carries the binary carry. In compare mode, it carries a running "equal so far" bit. In shift mode, it carries each cell's A bit one place up, so the word is doubled.

The external carry input enters the least significant cell. For a compare it should be held at 1. For a shift it is the bit that fills the vacated LSB. The block holds no state. The enumerated mode type plays the role that a state type plays in a sequential design.

Top module: `bitslice_alu`

## Requirements
- R1: With mode 2'b00 (logic), every result bit j equals fcode[3]·A[j]·B[j] + fcode[2]·A[j]·~B[j] + fcode[1]·~A[j]·B[j] + fcode[0]·~A[j]·~B[j], for all 16 codes.
- R2: In logic mode, code 4'b0000 yields all zeros, 4'b1111 yields all ones, 4'b1100 yields A and 4'b1010 yields B.
- R3: In logic mode, code 4'b0110 yields A XOR B, 4'b1001 yields A XNOR B and 4'b0011 yields the one's complement of A.
- R4: In logic mode, carry-out and the equality flag are both 0.
- R5: With mode 2'b01 (add), {carry-out, result} equals A + B + carry-in.
- R6: With mode 2'b10 (compare), result bit j is carry-in AND (A[j:0] == B[j:0]), and carry-out and the equality flag both equal carry-in AND (A == B).
- R7: With mode 2'b11 (shift left), the result is {A[W-2:0], carry-in} and carry-out is A[W-1].
- R8: Outside logic mode the function code has no effect on any output.
- R9: The equality flag is 0 in every mode other than compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4 | Operand A |
| opb_i | input | 4 | Operand B |
| fcode_i | input | 4 | Minterm enable code for logic mode |
| mode_i | input | 2 | 00 logic, 01 add, 10 compare, 11 shift left |
| cin_i | input | 1 | Carry, equality seed or shift-in bit entering cell 0 |
| res_o | output | 4 | Result word |
| cout_o | output | 1 | Ripple path leaving the top cell |
| eq_o | output | 1 | Whole-word equality in compare mode |

## Verification
The bench first aims at the add carry into and out of the top cell, using operands such as 4'hF plus 1 with carry-in set. A chain wired wrongly there would give a sum off by a power of two, or would lose the carry-out.

In compare mode it tries pairs that differ only in the LSB or only in the MSB, and it also tries equal words with the seed at 0. A cell that ignored the incoming chain would flag a false match. The shift checks watch the old MSB leave through carry-out and the carry-in fill bit 0. Finally, an exhaustive sweep over all codes, modes and carry values catches any minterm wired to the wrong operand pair, and any code that leaks into a non-logic mode.

// File: rtl/bitslice_pkg.sv
package bitslice_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ADD   = 2'b01,
        MODE_EQ    = 2'b10,
        MODE_SHL   = 2'b11
    } alu_mode_e;

    localparam int unsigned FCODE_W = 4;
endpackage

// File: rtl/minterm_fn.sv
module minterm_fn
    import bitslice_pkg::*;
(
    input  logic               a,
    input  logic               b,
    input  logic [FCODE_W-1:0] code,
    output logic               y
);
    logic [FCODE_W-1:0] term;

    always_comb begin
        term[3] = a & b;
        term[2] = a & ~b;
        term[1] = ~a & b;
        term[0] = ~a & ~b;
        y = |(term & code);
    end

    always_comb begin
        AST_ONE_TERM: assert ($onehot(term)); // R1
    end
endmodule

// File: rtl/bitslice_cell.sv
module bitslice_cell
    import bitslice_pkg::*;
(
    input  logic               a,
    input  logic               b,
    input  logic               chain_in,
    input  logic [FCODE_W-1:0] code,
    input  alu_mode_e          mode,
    output logic               f,
    output logic               chain_out
);
    logic fn_bit;
    logic same;

    minterm_fn u_fn (
        .a    (a),
        .b    (b),
        .code (code),
        .y    (fn_bit)
    );

    assign same = ~(a ^ b);

    always_comb begin
        unique case (mode)
            MODE_LOGIC: begin
                f         = fn_bit;
                chain_out = 1'b0;
            end
            MODE_ADD: begin
                f         = a ^ b ^ chain_in;
                chain_out = (a & b) | (chain_in & (a ^ b));
            end
            MODE_EQ: begin
                f         = same & chain_in;
                chain_out = same & chain_in;
            end
            MODE_SHL: begin
                f         = chain_in;
                chain_out = a;
            end
            default: begin
                f         = 1'b0;
                chain_out = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (mode == MODE_SHL) begin
            AST_SHL_CARRY_IS_A: assert (chain_out == a); // R7
        end
        if (mode == MODE_EQ && !chain_in) begin
            AST_EQ_KILLED: assert (!f && !chain_out); // R6
        end
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    input  logic [FCODE_W-1:0] fcode_i,
    input  logic [1:0]         mode_i,
    input  logic               cin_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               cout_o,
    output logic               eq_o
);
    localparam int unsigned CHAIN_W = WIDTH + 1;

    alu_mode_e          mode;
    logic [CHAIN_W-1:0] chain;

    assign mode     = alu_mode_e'(mode_i);
    assign chain[0] = cin_i;

    for (genvar j = 0; j < WIDTH; j++) begin : g_cell
        bitslice_cell u_cell (
            .a         (opa_i[j]),
            .b         (opb_i[j]),
            .chain_in  (chain[j]),
            .code      (fcode_i),
            .mode      (mode),
            .f         (res_o[j]),
            .chain_out (chain[j+1])
        );
    end

    assign cout_o = chain[WIDTH];
    assign eq_o   = (mode == MODE_EQ) ? chain[WIDTH] : 1'b0;

    always_comb begin
        if (mode == MODE_ADD) begin
            AST_ADD_SUM: assert ({cout_o, res_o} == CHAIN_W'(opa_i) + CHAIN_W'(opb_i) + CHAIN_W'(cin_i)); // R5
        end
        if (mode == MODE_LOGIC) begin
            AST_LOGIC_NO_CARRY: assert (!cout_o && !eq_o); // R4
        end
        if (mode != MODE_EQ) begin
            AST_EQ_ONLY_IN_CMP: assert (!eq_o); // R9
        end
        if (mode == MODE_EQ) begin
            AST_EQ_WORD: assert (eq_o == (cin_i && (opa_i == opb_i))); // R6
        end
    end
endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa, opb, res;
    logic [3:0]   fcode;
    logic [1:0]   mode;
    logic         cin, cout, eq;
    int           n_checks = 0;
    int           n_fail = 0;
    int           cycles = 0;
    bit           done = 1'b0;

    bitslice_alu #(.WIDTH(W)) u_dut (
        .opa_i(opa), .opb_i(opb), .fcode_i(fcode), .mode_i(mode), .cin_i(cin),
        .res_o(res), .cout_o(cout), .eq_o(eq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [3:0] c, input logic [1:0] m, input logic ci);
        logic [W-1:0] f;
        logic co, e, run;
        f = '0; co = 1'b0; e = 1'b0;
        case (m)
            2'b00: for (int j = 0; j < W; j++)
                       f[j] = (c[3] & a[j] & b[j]) | (c[2] & a[j] & ~b[j]) |
                              (c[1] & ~a[j] & b[j]) | (c[0] & ~a[j] & ~b[j]);
            2'b01: {co, f} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
            2'b10: begin
                run = ci;
                for (int j = 0; j < W; j++) begin
                    run  = run & (a[j] == b[j]);
                    f[j] = run;
                end
                co = run; e = run;
            end
            default: begin f = {a[W-2:0], ci}; co = a[W-1]; end
        endcase
        return {e, co, f};
    endfunction

    task automatic apply_check(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic [3:0] c, input logic [1:0] m, input logic ci,
                               input logic [W+1:0] expv);
        @(posedge clk);
        opa = a; opb = b; fcode = c; mode = m; cin = ci;
        #(CLK_PERIOD/4);
        n_checks++;
        if ({eq, cout, res} !== expv) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h code=%b mode=%b cin=%b actual={eq,cout,f}=%b expected=%b",
                     req, a, b, c, m, ci, {eq, cout, res}, expv);
        end
    endtask

    task automatic t_idle;
        apply_check("R4", 4'h0, 4'h0, 4'h0, 2'b00, 1'b0, 6'b0);
    endtask

    task automatic t_named_codes;
        apply_check("R2", 4'hA, 4'h6, 4'b0000, 2'b00, 1'b1, {2'b00, 4'h0});
        apply_check("R2", 4'hA, 4'h6, 4'b1111, 2'b00, 1'b1, {2'b00, 4'hF});
        apply_check("R2", 4'hA, 4'h6, 4'b1100, 2'b00, 1'b0, {2'b00, 4'hA});
        apply_check("R2", 4'hA, 4'h6, 4'b1010, 2'b00, 1'b0, {2'b00, 4'h6});
        apply_check("R3", 4'hA, 4'h6, 4'b0110, 2'b00, 1'b0, {2'b00, 4'hC});
        apply_check("R3", 4'hA, 4'h6, 4'b1001, 2'b00, 1'b0, {2'b00, 4'h3});
        apply_check("R3", 4'hA, 4'h6, 4'b0011, 2'b00, 1'b1, {2'b00, 4'h5});
    endtask

    task automatic t_add;
        apply_check("R5", 4'hF, 4'h0, 4'h0, 2'b01, 1'b1, {2'b01, 4'h0});
        apply_check("R5", 4'h7, 4'h8, 4'hF, 2'b01, 1'b0, {2'b00, 4'hF});
        apply_check("R5", 4'hF, 4'hF, 4'h3, 2'b01, 1'b1, {2'b01, 4'hF});
    endtask

    task automatic t_eq;
        apply_check("R6", 4'h9, 4'h9, 4'h0, 2'b10, 1'b1, {2'b11, 4'hF});
        apply_check("R6", 4'h9, 4'h9, 4'h0, 2'b10, 1'b0, {2'b00, 4'h0});
        apply_check("R6", 4'h9, 4'h8, 4'h0, 2'b10, 1'b1, {2'b00, 4'h0});
        apply_check("R6", 4'h9, 4'h1, 4'h0, 2'b10, 1'b1, {2'b00, 4'h7});
    endtask

    task automatic t_shift;
        apply_check("R7", 4'h9, 4'h0, 4'h0, 2'b11, 1'b0, {2'b01, 4'h2});
        apply_check("R7", 4'h6, 4'hF, 4'hF, 2'b11, 1'b1, {2'b00, 4'hD});
    endtask

    task automatic t_sweep;
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 16; c++)
                for (int ci = 0; ci < 2; ci++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 16; b++)
                            apply_check(m == 0 ? "R1" : "R8_R9", W'(a), W'(b), 4'(c), 2'(m), 1'(ci),
                                        model(W'(a), W'(b), 4'(c), 2'(m), 1'(ci)));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        opa = '0; opb = '0; fcode = '0; mode = '0; cin = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_named_codes();
        t_add();
        t_eq();
        t_shift();
        t_sweep();
        finish_run();
    end
endmodule